// File: doc/BRIEF.md
# Autovectored interrupt acknowledge arbiter

This block sits between a video controller and a 68000-style CPU. The video controller raises two interrupt requests, one for horizontal events and one for vertical events. The block keeps one pending flag for each request, gates each flag with its own enable input, and drives the highest enabled pending level onto the CPU's active-low three-bit priority input.

The block detects an interrupt acknowledge cycle when all three function-code lines are high and address strobe is low. It ends the cycle by pulling the valid-peripheral-address line low, which makes the CPU take an autovector. In the same cycle it raises a separate acknowledge line back to the video controller. The level being acknowledged is read from address bits A3..A1, and only the pending flag for that level is cleared. Both strobes stay active until address strobe goes high.

Top module: `irq_autovec_arbiter`

## Requirements
- R1: During and directly after reset, both pending flags are clear, `iplN` is 3'b111, `vpaN` is 1 and `intAck` is 0.
- R2: `iplN` is the bitwise inverse of the highest enabled pending level. The horizontal source is level 4 (`iplN`=3'b011) and the vertical source is level 6 (`iplN`=3'b001). Level 6 wins over level 4. When neither source is both pending and enabled, `iplN` is 3'b111.
- R3: A high `hRaise` or `vRaise` sampled at a clock edge sets that source's pending flag. The flag then stays set through any number of cycles until its level is acknowledged.
- R4: Setting an enable input low masks that source at `iplN` in the same cycle and keeps its pending flag. Setting the enable high again brings the level back at `iplN` in the same cycle.
- R5: An acknowledge cycle is recognised only when `cpuFc` is 3'b111 and `cpuAsN` is 0 at a clock edge. Any other function code with address strobe low gives no response.
- R6: After an edge that recognises an acknowledge, `vpaN` is 0 and `intAck` is 1 together, starting from that edge.
- R7: `vpaN` and `intAck` stay asserted while `cpuAsN` stays 0. They drop at the first edge that samples `cpuAsN` high. They do not assert again within the same bus cycle.
- R8: At the edge that recognises an acknowledge, only the flag whose level equals `cpuAddr` (A3..A1) is cleared: 3'b100 clears horizontal and 3'b110 clears vertical. The other flag is unchanged.
- R9: If a source raises its request at the same edge that its flag is being cleared by an acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hRaise | input | 1 | Horizontal interrupt request from the video controller |
| vRaise | input | 1 | Vertical interrupt request from the video controller |
| hEnable | input | 1 | Enable for the horizontal source |
| vEnable | input | 1 | Enable for the vertical source |
| cpuFc | input | 3 | CPU function-code lines |
| cpuAsN | input | 1 | CPU address strobe, active low |
| cpuAddr | input | 3 | CPU address bits A3..A1 |
| iplN | output | 3 | Active-low interrupt priority level to the CPU |
| vpaN | output | 1 | Valid peripheral address to the CPU, active low |
| intAck | output | 1 | Acknowledge-complete strobe to the video controller |

## Verification
The bench builds the block with its default parameters: a three-bit level field, the horizontal source at level 4 and the vertical source at level 6. These values make every `iplN` code the block can produce reachable: idle, the horizontal level alone, the vertical level alone, and the vertical level winning over the horizontal one. With only two sources at fixed levels, the bench can raise both sources together and acknowledge each level in turn. It can also acknowledge a level at the same edge that its source raises again, and send a function code that is not an acknowledge with address strobe low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef struct packed {
    logic clrH;
    logic clrV;
  } ackStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } ackState_t;

endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_arb_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int FC_W    = 3,
  parameter int H_LEVEL = 4,
  parameter int V_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FC_W-1:0]    cpuFc,
  input  logic               cpuAsN,
  input  logic [LEVEL_W-1:0] cpuAddr,
  output logic               vpaN,
  output logic               intAck,
  output ackStrobe_t         strobes
);

  localparam logic [LEVEL_W-1:0] H_CODE = LEVEL_W'(H_LEVEL);
  localparam logic [LEVEL_W-1:0] V_CODE = LEVEL_W'(V_LEVEL);

  ackState_t state, stateNext;
  logic      iackSeen;

  assign iackSeen = (cpuFc == {FC_W{1'b1}}) && !cpuAsN;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (iackSeen) stateNext = ST_ACK;
      ST_ACK:  if (cpuAsN)   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.clrH = (state == ST_IDLE) && iackSeen && (cpuAddr == H_CODE);
    strobes.clrV = (state == ST_IDLE) && iackSeen && (cpuAddr == V_CODE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign intAck = (state == ST_ACK);
  assign vpaN   = (state != ST_ACK);

  assert_ack_needs_iack_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intAck) |-> $past((cpuFc == {FC_W{1'b1}}) && !cpuAsN));

  assert_drop_on_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && cpuAsN) |=> !intAck);

  assert_hold_while_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !cpuAsN) |=> (intAck && !vpaN));

  assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clrH, strobes.clrV}));

endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_arb_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int H_LEVEL = 4,
  parameter int V_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hRaise,
  input  logic               vRaise,
  input  logic               hEnable,
  input  logic               vEnable,
  input  ackStrobe_t         strobes,
  output logic [LEVEL_W-1:0] iplN
);

  localparam logic [LEVEL_W-1:0] H_CODE  = LEVEL_W'(H_LEVEL);
  localparam logic [LEVEL_W-1:0] V_CODE  = LEVEL_W'(V_LEVEL);
  localparam bit                 V_FIRST = (V_LEVEL >= H_LEVEL);

  logic               hPend, vPend;
  logic               hLive, vLive;
  logic [LEVEL_W-1:0] level;

  // A new request outranks a clear in the same cycle (R9).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPend <= 1'b0;
      vPend <= 1'b0;
    end else begin
      hPend <= hRaise || (hPend && !strobes.clrH);
      vPend <= vRaise || (vPend && !strobes.clrV);
    end
  end

  assign hLive = hPend && hEnable;
  assign vLive = vPend && vEnable;

  generate
    if (V_FIRST) begin : g_vFirst
      always_comb begin
        if (vLive)      level = V_CODE;
        else if (hLive) level = H_CODE;
        else            level = '0;
      end
    end else begin : g_hFirst
      always_comb begin
        if (hLive)      level = H_CODE;
        else if (vLive) level = V_CODE;
        else            level = '0;
      end
    end
  endgenerate

  assign iplN = ~level;

  assert_h_pend_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hPend && !strobes.clrH) |=> hPend);

  assert_v_pend_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vPend && !strobes.clrV) |=> vPend);

  assert_masked_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hEnable && !vEnable) |-> (iplN == {LEVEL_W{1'b1}}));

endmodule

// File: rtl/irq_autovec_arbiter.sv
module irq_autovec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int FC_W    = 3,
  parameter int H_LEVEL = 4,
  parameter int V_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hRaise,
  input  logic               vRaise,
  input  logic               hEnable,
  input  logic               vEnable,
  input  logic [FC_W-1:0]    cpuFc,
  input  logic               cpuAsN,
  input  logic [LEVEL_W-1:0] cpuAddr,
  output logic [LEVEL_W-1:0] iplN,
  output logic               vpaN,
  output logic               intAck
);

  ackStrobe_t strobes;

  irq_ack_ctrl #(
    .LEVEL_W(LEVEL_W), .FC_W(FC_W), .H_LEVEL(H_LEVEL), .V_LEVEL(V_LEVEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuFc(cpuFc), .cpuAsN(cpuAsN),
    .cpuAddr(cpuAddr), .vpaN(vpaN), .intAck(intAck), .strobes(strobes)
  );

  irq_pend_dp #(
    .LEVEL_W(LEVEL_W), .H_LEVEL(H_LEVEL), .V_LEVEL(V_LEVEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hRaise(hRaise), .vRaise(vRaise),
    .hEnable(hEnable), .vEnable(vEnable), .strobes(strobes), .iplN(iplN)
  );

  assert_vpa_with_intak_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intAck) |-> $fell(vpaN));

endmodule

// File: tb/irq_autovec_arbiter_tb.sv
module irq_autovec_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hRaise = 1'b0, vRaise = 1'b0;
  logic       hEnable = 1'b1, vEnable = 1'b1;
  logic [2:0] cpuFc = 3'b000;
  logic       cpuAsN = 1'b1;
  logic [2:0] cpuAddr = 3'b000;
  logic [2:0] iplN;
  logic       vpaN, intAck;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference state
  bit mH = 0, mV = 0, mAck = 0;

  always #10 clk = ~clk;

  irq_autovec_arbiter u_dut (
    .clk(clk), .rstN(rstN), .hRaise(hRaise), .vRaise(vRaise),
    .hEnable(hEnable), .vEnable(vEnable), .cpuFc(cpuFc), .cpuAsN(cpuAsN),
    .cpuAddr(cpuAddr), .iplN(iplN), .vpaN(vpaN), .intAck(intAck)
  );

  function automatic logic [2:0] expIpl();
    int lvl;
    if (mV && vEnable)      lvl = 6;
    else if (mH && hEnable) lvl = 4;
    else                    lvl = 0;
    return ~3'(lvl);
  endfunction

  task automatic compare(string tag);
    logic [2:0] eIpl;
    eIpl = expIpl();
    vectors++;
    if (iplN !== eIpl || vpaN !== !mAck || intAck !== mAck) begin
      misses++;
      $display("FAIL %s: iplN=%b vpaN=%b intAck=%b expected iplN=%b vpaN=%b intAck=%b",
               tag, iplN, vpaN, intAck, eIpl, !mAck, mAck);
    end
  endtask

  task automatic step(string tag);
    bit iack, clrH, clrV;
    @(posedge clk);
    iack = (cpuFc == 3'b111) && !cpuAsN;
    clrH = 0;
    clrV = 0;
    if (!mAck) begin
      if (iack) begin
        mAck = 1;
        clrH = (cpuAddr == 3'd4);
        clrV = (cpuAddr == 3'd6);
      end
    end else if (cpuAsN) begin
      mAck = 0;
    end
    mH = hRaise || (mH && !clrH);
    mV = vRaise || (mV && !clrV);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic ackCycle(logic [2:0] lvl, int holdCycles, string tag);
    cpuFc = 3'b111; cpuAddr = lvl; cpuAsN = 1'b0;
    idle(holdCycles, tag);
    cpuAsN = 1'b1;
    idle(2, tag);
    cpuFc = 3'b000; cpuAddr = 3'b000;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    idle(2, "R1 after reset");

    // R3 and R2: horizontal request gives level 4
    hRaise = 1'b1; step("R3 raise h");
    hRaise = 1'b0; idle(4, "R3 h held, R2 level 4");

    // R4: mask keeps flag, unmask restores the level at once
    hEnable = 1'b0; #1; compare("R4 masked");
    idle(3, "R4 masked held");
    hEnable = 1'b1; #1; compare("R4 unmasked");
    idle(1, "R4 unmasked");

    // R2: vertical wins over horizontal
    vRaise = 1'b1; step("R2 raise v");
    vRaise = 1'b0; idle(2, "R2 level 6 wins");

    // R5: other function code with strobe low is ignored
    cpuFc = 3'b101; cpuAddr = 3'd6; cpuAsN = 1'b0;
    idle(3, "R5 non-ack fc");
    cpuAsN = 1'b1; cpuFc = 3'b000; idle(1, "R5 idle");

    // R6, R7, R8: acknowledge level 6, horizontal stays
    ackCycle(3'd6, 4, "R6 R7 R8 ack level 6");
    idle(2, "R8 h remains");

    // R7: function code stays at ack with strobe high, no re-assert
    cpuFc = 3'b111; cpuAddr = 3'd4; idle(2, "R7 strobe high");
    cpuFc = 3'b000;

    // R8: acknowledge level 4 clears horizontal
    ackCycle(3'd4, 2, "R8 ack level 4");
    idle(1, "R2 idle 7");

    // R8: both pending, ack level 4 clears only horizontal
    hRaise = 1'b1; vRaise = 1'b1; step("R2 both raise");
    hRaise = 1'b0; vRaise = 1'b0; idle(1, "R2 both");
    ackCycle(3'd4, 2, "R8 ack 4 with both");
    vEnable = 1'b0; #1; compare("R8 h cleared, v masked");
    vEnable = 1'b1; #1; compare("R4 v back");

    // R9: raise vertical at the clearing edge
    cpuFc = 3'b111; cpuAddr = 3'd6; cpuAsN = 1'b0; vRaise = 1'b1;
    step("R9 raise during clear");
    vRaise = 1'b0; idle(1, "R9 held");
    cpuAsN = 1'b1; idle(2, "R9 release");
    cpuFc = 3'b000;
    idle(2, "R9 still pending");

    // R5: ack of an unused level still terminates, clears nothing
    ackCycle(3'd2, 2, "R5 ack other level");
    idle(2, "R8 nothing cleared");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule